// File: doc/BRIEF.md
# Byte and Halfword Access Unit over a Word Memory

This block gives a 32-bit load/store core byte, halfword and word access to a data store that holds only whole 32-bit words. The core presents a byte address, an access size, a signedness flag, store data and separate read and write enables. The unit drops the two lowest address bits to pick a word. It uses those two bits as a lane offset, so the addressed byte or halfword is moved to or from the bottom of the word by rotation.

Loads are combinational from the current contents. The selected lane is rotated down to bit 0 and then extended to 32 bits with sign or zero fill. Stores use read-modify-write. The addressed word is rotated down by the lane offset and its lowest byte or halfword is replaced with the store data. The result is rotated back up by the same amount and written at the clock edge. Word accesses bypass rotation. Accesses that would cross a word boundary are not handled; a halfword access simply ignores address bit 0.

Top module: `lane_align_mem`

## Requirements
- R1: The word selected is address bits [log2(WORDS)+1:2]; higher address bits are ignored, so addresses that differ only there reach the same word.
- R2: While rst_n is low, every word is cleared to zero.
- R3: The acc_size encoding is 00 byte, 01 halfword, 10 word, and 11 is treated as word. A word load returns the stored word unchanged.
- R4: A byte load returns the byte at offset addr[1:0], where offset 0 is bits 7:0 and offset 3 is bits 31:24. When acc_unsigned is 0 it is sign-extended from bit 7; when it is 1 it is zero-extended.
- R5: A halfword load returns bits 15:0 when addr[1] is 0 and bits 31:16 when addr[1] is 1, ignoring addr[0]. It is extended from bit 15 under the same rule as R4.
- R6: A byte store writes wr_data[7:0] into the addressed byte and leaves the other three bytes unchanged.
- R7: A halfword store writes wr_data[15:0] into the halfword chosen by addr[1], ignoring addr[0], and leaves the other halfword unchanged.
- R8: A word store writes all 32 bits of wr_data, whatever addr[1:0] holds.
- R9: A store takes effect at the rising clock edge where wr_en is high. A load in that same cycle returns the contents from before the store.
- R10: When rd_en is low, rd_data is zero.
- R11: When wr_en is low, no word changes at the clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; stores occur on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset, clears the store |
| acc_addr | input | ADDR_W | Byte address |
| acc_size | input | 2 | Access size: 00 byte, 01 halfword, 10/11 word |
| acc_unsigned | input | 1 | 1 selects zero extension on loads, 0 selects sign extension |
| rd_en | input | 1 | Load enable |
| wr_en | input | 1 | Store enable |
| wr_data | input | 32 | Store data, taken from the low lane for sub-word sizes |
| rd_data | output | 32 | Extended load result, zero when rd_en is low |

## Verification
The bench builds the unit with WORDS set to 16. Random 32-bit addresses therefore alias onto a handful of words, so most stores land on words that earlier stores partly wrote. That load puts pressure on the read-modify-write merge at every lane offset. The small depth also makes the address-bit cut-off of R1 easy to observe with high address values. Directed cases add sign-bit patterns in each byte, odd halfword addresses, size code 11 and a load issued in the same cycle as a store.

// File: rtl/lane_align_mem.sv
module lane_align_mem #(
  parameter int WORDS  = 256,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [1:0]        acc_size,
  input  logic              acc_unsigned,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [31:0]       wr_data,
  output logic [31:0]       rd_data
);
  localparam int IDX_W = $clog2(WORDS);

  logic [31:0] mem [WORDS];

  logic [IDX_W-1:0] idx;
  logic [1:0]       lane;
  logic [4:0]       sh;
  logic [31:0]      cur, rot_dn, merged, new_word, load_val;
  logic [63:0]      dn2, up2;
  logic             unused_hi;

  assign idx  = acc_addr[IDX_W+1:2];
  assign unused_hi = ^acc_addr[ADDR_W-1:IDX_W+2];
  assign lane = (acc_size == 2'b00) ? acc_addr[1:0] :
                (acc_size == 2'b01) ? {acc_addr[1], 1'b0} : 2'b00;
  assign sh   = {lane, 3'b000};
  assign cur  = mem[idx];

  assign dn2    = {cur, cur} >> sh;
  assign rot_dn = dn2[31:0];

  always_comb begin
    case (acc_size)
      2'b00:   merged = {rot_dn[31:8], wr_data[7:0]};
      2'b01:   merged = {rot_dn[31:16], wr_data[15:0]};
      default: merged = wr_data;
    endcase
  end

  assign up2      = {merged, merged} << sh;
  assign new_word = up2[63:32];

  always_comb begin
    case (acc_size)
      2'b00:   load_val = {{24{~acc_unsigned & rot_dn[7]}}, rot_dn[7:0]};
      2'b01:   load_val = {{16{~acc_unsigned & rot_dn[15]}}, rot_dn[15:0]};
      default: load_val = rot_dn;
    endcase
  end

  assign rd_data = rd_en ? load_val : 32'd0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) mem[i] <= '0;
    end else if (wr_en) begin
      mem[idx] <= new_word;
    end
  end

  logic [31:0] lane_mask;
  assign lane_mask = (acc_size == 2'b00) ? (32'h0000_00FF << sh) :
                     (acc_size == 2'b01) ? (32'h0000_FFFF << sh) : 32'hFFFF_FFFF;

  // R6 R7 R8
  keep_other_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ((mem[$past(idx)] & ~$past(lane_mask)) == ($past(cur) & ~$past(lane_mask))));

  // R6 R7 R8
  lane_written_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ((mem[$past(idx)] & $past(lane_mask)) ==
               (($past(wr_data) << $past(sh)) & $past(lane_mask))));

  // R11
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> (mem[$past(idx)] == $past(cur)));

  // R10
  rd_idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |-> (rd_data == 32'd0));

  // R4
  byte_sext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && acc_size == 2'b00 && !acc_unsigned) |-> (rd_data[31:8] == {24{rd_data[7]}}));

  // R4
  byte_zext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && acc_size == 2'b00 && acc_unsigned) |-> (rd_data[31:8] == 24'd0));

  // R5
  half_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && acc_size == 2'b01) |->
      (rd_data[31:16] == (acc_unsigned ? 16'd0 : {16{rd_data[15]}})));
endmodule

// File: tb/lane_align_mem_test.sv
module lane_align_mem_test;
  localparam int WORDS = 16;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] acc_addr;
  logic [1:0]  acc_size;
  logic        acc_unsigned;
  logic        rd_en, wr_en;
  logic [31:0] wr_data;
  logic [31:0] rd_data;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [31:0] model [WORDS];

  always #2 clk = ~clk;

  lane_align_mem #(.WORDS(WORDS), .ADDR_W(32)) uut (
    .clk(clk), .rst_n(rst_n), .acc_addr(acc_addr), .acc_size(acc_size),
    .acc_unsigned(acc_unsigned), .rd_en(rd_en), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data)
  );

  function automatic int widx(input logic [31:0] a);
    return int'(a[5:2]);
  endfunction

  function automatic logic [31:0] exp_load(input logic [31:0] w, input logic [31:0] a,
                                           input logic [1:0] sz, input logic uns);
    logic [7:0]  b;
    logic [15:0] h;
    b = w[8*a[1:0] +: 8];
    h = a[1] ? w[31:16] : w[15:0];
    if (sz == 2'b00) return uns ? {24'd0, b} : {{24{b[7]}}, b};
    if (sz == 2'b01) return uns ? {16'd0, h} : {{16{h[15]}}, h};
    return w;
  endfunction

  function automatic logic [31:0] exp_store(input logic [31:0] w, input logic [31:0] a,
                                            input logic [1:0] sz, input logic [31:0] d);
    logic [31:0] r;
    r = w;
    if (sz == 2'b00) r[8*a[1:0] +: 8] = d[7:0];
    else if (sz == 2'b01) begin
      if (a[1]) r[31:16] = d[15:0];
      else r[15:0] = d[15:0];
    end else r = d;
    return r;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic op(input logic [31:0] a, input logic [1:0] sz, input logic uns,
                    input logic re, input logic we, input logic [31:0] d, input string tag);
    @(negedge clk);
    acc_addr = a; acc_size = sz; acc_unsigned = uns;
    rd_en = re; wr_en = we; wr_data = d;
    #1;
    if (re) chk(tag, rd_data, exp_load(model[widx(a)], a, sz, uns));
    else chk(tag, rd_data, 32'd0);
    @(posedge clk);
    if (we) model[widx(a)] = exp_store(model[widx(a)], a, sz, d);
  endtask

  initial begin
    #(4 * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < WORDS; i++) model[i] = 32'hDEAD_BEEF;
    rst_n = 1'b0; acc_addr = 0; acc_size = 2'b10; acc_unsigned = 0;
    rd_en = 0; wr_en = 0; wr_data = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    for (int i = 0; i < WORDS; i++) model[i] = 32'd0;

    for (int i = 0; i < WORDS; i++) op(32'(i * 4), 2'b10, 0, 1, 0, 0, "R2 reset word");

    op(32'h0, 2'b10, 0, 1, 1, 32'h80FF_7F01, "R9 load beside store");
    op(32'h0, 2'b10, 0, 1, 0, 0, "R3 word load");
    op(32'h3, 2'b11, 0, 1, 0, 0, "R3 size 11 as word");
    for (int o = 0; o < 4; o++) begin
      op(32'(o), 2'b00, 0, 1, 0, 0, "R4 byte signed");
      op(32'(o), 2'b00, 1, 1, 0, 0, "R4 byte unsigned");
    end
    for (int o = 0; o < 4; o++) begin
      op(32'(o), 2'b01, 0, 1, 0, 0, "R5 half signed");
      op(32'(o), 2'b01, 1, 1, 0, 0, "R5 half unsigned");
    end
    op(32'h3, 2'b00, 0, 0, 1, 32'hFFFF_FFA5, "R10 idle read");
    op(32'h0, 2'b10, 0, 1, 0, 0, "R6 byte store lane3");
    op(32'h1, 2'b00, 0, 0, 1, 32'h0000_003C, "R10 idle read");
    op(32'h0, 2'b10, 0, 1, 0, 0, "R6 byte store lane1");
    op(32'h7, 2'b01, 0, 0, 1, 32'h1234_BEEF, "R7 half store odd");
    op(32'h4, 2'b10, 0, 1, 0, 0, "R7 half store upper");
    op(32'h5, 2'b01, 0, 0, 1, 32'hAAAA_8001, "R7 half store low");
    op(32'h4, 2'b10, 0, 1, 0, 0, "R7 half store result");
    op(32'h9, 2'b10, 0, 0, 1, 32'hCAFE_F00D, "R8 word store offset");
    op(32'h8, 2'b10, 0, 1, 0, 0, "R8 word store result");
    op(32'hFFFF_FFC8, 2'b10, 0, 1, 0, 0, "R1 alias high bits");
    op(32'h8000_0008, 2'b00, 0, 0, 1, 32'h77, "R1 alias store");
    op(32'h8, 2'b10, 0, 1, 0, 0, "R1 alias result");
    op(32'h8, 2'b10, 0, 1, 0, 32'h1111_1111, "R11 no write");
    op(32'h8, 2'b10, 0, 1, 0, 0, "R11 unchanged");

    for (int n = 0; n < 600; n++) begin
      logic [31:0] a;
      logic [1:0]  sz;
      logic        we;
      a  = $urandom;
      sz = 2'($urandom);
      we = ($urandom % 2) == 0;
      op(a, sz, 1'($urandom), 1'($urandom % 4 != 0), we, $urandom,
         we ? "R6 R7 R8 random" : "R4 R5 R11 random");
    end

    for (int i = 0; i < WORDS; i++)
      op({20'hABCDE, 6'(i), 6'(i * 4)} , 2'b10, 0, 1, 0, 0, "R1 sweep");

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule